// File: doc/BRIEF.md
# Sync Flag Wait and Signal Unit

This block keeps a bank of signed counters ("sync flags") that a dual-slot scalar sequencer uses to order DMA traffic against its own instruction stream. A wait instruction names a flag, one of six conditions and a comparison operand. The unit raises `stall` for as long as the condition is false, and the sequencer holds the instruction in place and presents it again on each following cycle. A sync-add instruction atomically adds a signed operand to a flag. A separate event port lets DMA engines bump any flag on any cycle, and the instruction add and the event add may land on the same flag together.

Two further 32-bit registers, a done-completion register and a public-access register, can be written and read back. These accesses are legal only from issue slot 1. A typical gather pairs the pieces: it waits until a flag reaches a byte count, clears the flag by adding the negated count, waits until another flag is exactly zero, and then publishes completion by writing the done register.

Top module: `syncflag_unit`

## Requirements
- R1: After reset every flag, the done register and the public register read as zero, `stall` is low and `rd_valid` is low.
- R2: Wait opcodes are 4 = DONE, 5 = equal, 6 = not-equal, 7 = greater-than, 8 = greater-or-equal, 9 = less-than, each comparing flag (left) against operand (right). With `ins_valid` high, `stall` is high in the same cycle exactly when the condition is false. A DONE wait is met when the flag is non-zero.
- R3: Wait comparisons treat flag and operand as signed two's complement values.
- R4: Opcode 10 (sync add) adds `ins_operand` to flag `ins_flag` at the next clock edge, wrapping modulo 2^32. It never stalls.
- R5: `evt_valid` adds `evt_amount` to flag `evt_flag` at the next clock edge, independently of the instruction port.
- R6: When an instruction add and an event add target the same flag in the same cycle, the flag gains the sum of both amounts, each counted once.
- R7: From slot 1 (`ins_slot` = 1), opcode 22 writes `ins_operand` into the done register and opcode 24 writes it into the public register at the next edge. Opcode 21 reads the done register and opcode 23 reads the public register: in the next cycle `rd_valid` is high for one cycle and `rd_data` holds the value the register had in the read cycle.
- R8: Opcodes 21 to 24 issued from slot 0 change no register and leave `rd_valid` low.
- R9: Any other opcode, or any cycle with `ins_valid` low, changes no flag, keeps `stall` low and leaves `rd_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_slot | input | 1 | Issue slot of the instruction (0 or 1) |
| ins_op | input | 6 | Opcode |
| ins_flag | input | IDX_W (4) | Flag index |
| ins_operand | input | DATA_W (32) | Compare value, add amount or write data |
| stall | output | 1 | Wait condition not yet met; hold the instruction |
| evt_valid | input | 1 | External event add request |
| evt_flag | input | IDX_W (4) | Flag index for the event add |
| evt_amount | input | DATA_W (32) | Signed amount for the event add |
| rd_valid | output | 1 | Completion-register read data valid |
| rd_data | output | DATA_W (32) | Completion-register read data |

## Verification
`stall` is combinational, so the bench drives an instruction on the falling edge and samples `stall` one time unit later, in the same cycle. Flag updates from either add path take effect at the next rising edge. The bench applies them to its model at that edge and checks them through the wait conditions of later instructions. Completion-register reads are due exactly one cycle after issue, so `rd_valid` and `rd_data` are sampled on the falling edge that follows the issuing cycle's rising edge and are compared with the model value captured before that edge's writes.

// File: rtl/syncflag_pkg.sv
package syncflag_pkg;

   localparam int OP_W = 6;
   typedef logic [OP_W-1:0] opcode_t;

   // wait family, ordinals fixed by the instruction set
   localparam opcode_t OPC_WAIT_DONE = 6'd4;
   localparam opcode_t OPC_WAIT_EQ   = 6'd5;
   localparam opcode_t OPC_WAIT_NE   = 6'd6;
   localparam opcode_t OPC_WAIT_GT   = 6'd7;
   localparam opcode_t OPC_WAIT_GE   = 6'd8;
   localparam opcode_t OPC_WAIT_LT   = 6'd9;
   localparam opcode_t OPC_SYNC_ADD  = 6'd10;
   // completion register accessors (restricted slot)
   localparam opcode_t OPC_RD_DONE   = 6'd21;
   localparam opcode_t OPC_WR_DONE   = 6'd22;
   localparam opcode_t OPC_RD_PUB    = 6'd23;
   localparam opcode_t OPC_WR_PUB    = 6'd24;

   typedef enum logic [2:0] {
      CND_DONE = 3'd0,
      CND_EQ   = 3'd1,
      CND_NE   = 3'd2,
      CND_GT   = 3'd3,
      CND_GE   = 3'd4,
      CND_LT   = 3'd5
   } wait_cond_e;

   function automatic logic is_wait_op(opcode_t op);
      return (op >= OPC_WAIT_DONE) && (op <= OPC_WAIT_LT);
   endfunction

   function automatic wait_cond_e cond_of(opcode_t op);
      opcode_t delta;
      delta = op - OPC_WAIT_DONE;
      return wait_cond_e'(delta[2:0]);
   endfunction

endpackage

// File: rtl/syncflag_cond.sv
module syncflag_cond
   import syncflag_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  wait_cond_e        cond,
   input  logic [DATA_W-1:0] flag_val,
   input  logic [DATA_W-1:0] operand,
   output logic              met
);

   logic is_eq;
   logic is_gt;
   logic is_lt;

   assign is_eq = (flag_val == operand);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_gt = ($signed(flag_val) > $signed(operand));
         assign is_lt = ($signed(flag_val) < $signed(operand));
      end else begin : g_unsigned
         assign is_gt = (flag_val > operand);
         assign is_lt = (flag_val < operand);
      end
   endgenerate

   always_comb begin
      unique case (cond)
         CND_DONE: met = |flag_val;
         CND_EQ:   met = is_eq;
         CND_NE:   met = !is_eq;
         CND_GT:   met = is_gt;
         CND_GE:   met = !is_lt;
         CND_LT:   met = is_lt;
         default:  met = 1'b0;
      endcase
   end

endmodule

// File: rtl/syncflag_bank.sv
module syncflag_bank #(
   parameter int NUM_FLAGS = 16,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        add_en,
   input  logic [IDX_W-1:0]            add_idx,
   input  logic [DATA_W-1:0]           add_amt,
   input  logic                        evt_en,
   input  logic [IDX_W-1:0]            evt_idx,
   input  logic [DATA_W-1:0]           evt_amt,
   input  logic [IDX_W-1:0]            sel_idx,
   output logic [DATA_W-1:0]           sel_val,
   output logic [NUM_FLAGS*DATA_W-1:0] flag_vec
);

   logic [DATA_W-1:0] flag_q [NUM_FLAGS];

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         logic              hit_ins;
         logic              hit_evt;
         logic [DATA_W-1:0] inc_ins;
         logic [DATA_W-1:0] inc_evt;

         assign hit_ins = add_en && (add_idx == IDX_W'(g));
         assign hit_evt = evt_en && (evt_idx == IDX_W'(g));
         assign inc_ins = hit_ins ? add_amt : '0;
         assign inc_evt = hit_evt ? evt_amt : '0;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q[g] <= '0;
            end else if (hit_ins || hit_evt) begin
               flag_q[g] <= flag_q[g] + inc_ins + inc_evt;
            end
         end

         assign flag_vec[g*DATA_W +: DATA_W] = flag_q[g];
      end
   endgenerate

   assign sel_val = flag_q[sel_idx];

endmodule

// File: rtl/syncflag_compreg.sv
module syncflag_compreg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_done,
   input  logic              wr_pub,
   input  logic              rd_done,
   input  logic              rd_pub,
   input  logic [DATA_W-1:0] wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] done_val
);

   logic [DATA_W-1:0] done_q;
   logic [DATA_W-1:0] pub_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q   <= '0;
         pub_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (wr_done) done_q <= wdata;
         if (wr_pub)  pub_q  <= wdata;
         rd_valid <= rd_done || rd_pub;
         if (rd_done) begin
            rd_data <= done_q;
         end else if (rd_pub) begin
            rd_data <= pub_q;
         end
      end
   end

   assign done_val = done_q;

endmodule

// File: rtl/syncflag_unit.sv
module syncflag_unit
   import syncflag_pkg::*;
#(
   parameter int NUM_FLAGS  = 16,
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1,
   parameter bit COMP_SLOT  = 1'b1,
   localparam int IDX_W     = $clog2(NUM_FLAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic              ins_slot,
   input  logic [OP_W-1:0]   ins_op,
   input  logic [IDX_W-1:0]  ins_flag,
   input  logic [DATA_W-1:0] ins_operand,
   output logic              stall,
   input  logic              evt_valid,
   input  logic [IDX_W-1:0]  evt_flag,
   input  logic [DATA_W-1:0] evt_amount,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (NUM_FLAGS < 2 || (NUM_FLAGS & (NUM_FLAGS - 1)) != 0) begin : g_bad_flags
         $error("syncflag_unit: NUM_FLAGS must be a power of two, at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("syncflag_unit: DATA_W must be at least 2");
      end
   endgenerate

   // decode
   logic       op_wait;
   logic       op_add;
   logic       slot_ok;
   logic       comp_go;
   wait_cond_e cond;

   assign op_wait = ins_valid && is_wait_op(ins_op);
   assign op_add  = ins_valid && (ins_op == OPC_SYNC_ADD);
   assign slot_ok = (ins_slot == COMP_SLOT);
   assign comp_go = ins_valid && slot_ok;
   assign cond    = cond_of(ins_op);

   logic [DATA_W-1:0]           sel_val;
   logic [NUM_FLAGS*DATA_W-1:0] flag_vec;
   logic [DATA_W-1:0]           done_val;
   logic                        cond_met;

   syncflag_bank #(
      .NUM_FLAGS (NUM_FLAGS),
      .DATA_W    (DATA_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (op_add),
      .add_idx  (ins_flag),
      .add_amt  (ins_operand),
      .evt_en   (evt_valid),
      .evt_idx  (evt_flag),
      .evt_amt  (evt_amount),
      .sel_idx  (ins_flag),
      .sel_val  (sel_val),
      .flag_vec (flag_vec)
   );

   syncflag_cond #(
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cond (
      .cond     (cond),
      .flag_val (sel_val),
      .operand  (ins_operand),
      .met      (cond_met)
   );

   assign stall = op_wait && !cond_met;

   syncflag_compreg #(
      .DATA_W (DATA_W)
   ) u_comp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_done  (comp_go && (ins_op == OPC_WR_DONE)),
      .wr_pub   (comp_go && (ins_op == OPC_WR_PUB)),
      .rd_done  (comp_go && (ins_op == OPC_RD_DONE)),
      .rd_pub   (comp_go && (ins_op == OPC_RD_PUB)),
      .wdata    (ins_operand),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .done_val (done_val)
   );

endmodule

// File: rtl/syncflag_unit_chk.sv
module syncflag_unit_chk
   import syncflag_pkg::*;
#(
   parameter int NUM_FLAGS = 16,
   parameter int DATA_W    = 32,
   parameter bit COMP_SLOT = 1'b1,
   localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ins_valid,
   input logic                        ins_slot,
   input logic [OP_W-1:0]             ins_op,
   input logic [IDX_W-1:0]            ins_flag,
   input logic [DATA_W-1:0]           ins_operand,
   input logic                        stall,
   input logic                        evt_valid,
   input logic [IDX_W-1:0]            evt_flag,
   input logic [DATA_W-1:0]           evt_amount,
   input logic                        rd_valid,
   input logic [NUM_FLAGS*DATA_W-1:0] flag_vec,
   input logic [DATA_W-1:0]           done_val
);

   logic [DATA_W-1:0] fl [NUM_FLAGS];
   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_unpack
      assign fl[g] = flag_vec[g*DATA_W +: DATA_W];
   end

   logic [IDX_W-1:0]  ins_idx_q;
   logic [IDX_W-1:0]  evt_idx_q;
   logic [DATA_W-1:0] sel_ins;
   logic [DATA_W-1:0] sel_evt;
   logic [DATA_W-1:0] sum_ins;
   logic [DATA_W-1:0] sum_evt;
   logic [DATA_W-1:0] sum_both;
   logic              is_add;
   logic              same_flag;
   logic              comp_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_idx_q <= '0;
         evt_idx_q <= '0;
      end else begin
         ins_idx_q <= ins_flag;
         evt_idx_q <= evt_flag;
      end
   end

   assign sel_ins   = fl[ins_flag];
   assign sel_evt   = fl[evt_flag];
   assign sum_ins   = sel_ins + ins_operand;
   assign sum_evt   = sel_evt + evt_amount;
   assign sum_both  = sel_ins + ins_operand + evt_amount;
   assign is_add    = ins_valid && (ins_op == OPC_SYNC_ADD);
   assign same_flag = evt_valid && (evt_flag == ins_flag);
   assign comp_rd   = ins_valid && ((ins_op == OPC_RD_DONE) || (ins_op == OPC_RD_PUB));

   AST_STALL_ONLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ins_valid && ins_op >= OPC_WAIT_DONE && ins_op <= OPC_WAIT_LT)); // R9

   AST_DONE_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_op == OPC_WAIT_DONE && sel_ins != '0) |-> !stall); // R2

   AST_DONE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_op == OPC_WAIT_DONE && sel_ins == '0) |-> stall); // R2

   AST_ADD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_add && !same_flag) |=> (fl[ins_idx_q] == $past(sum_ins))); // R4

   AST_EVT_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !(is_add && evt_flag == ins_flag)) |=> (fl[evt_idx_q] == $past(sum_evt))); // R5

   AST_DUAL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_add && same_flag) |=> (fl[ins_idx_q] == $past(sum_both))); // R6

   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_rd && ins_slot == COMP_SLOT) |=> rd_valid); // R7

   AST_WRONG_SLOT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ins_valid && ins_slot == COMP_SLOT)) |=> !rd_valid); // R8

   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ins_valid && ins_slot == COMP_SLOT && ins_op == OPC_WR_DONE)) |=> $stable(done_val)); // R8

endmodule

bind syncflag_unit syncflag_unit_chk #(
   .NUM_FLAGS (NUM_FLAGS),
   .DATA_W    (DATA_W),
   .COMP_SLOT (COMP_SLOT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ins_valid   (ins_valid),
   .ins_slot    (ins_slot),
   .ins_op      (ins_op),
   .ins_flag    (ins_flag),
   .ins_operand (ins_operand),
   .stall       (stall),
   .evt_valid   (evt_valid),
   .evt_flag    (evt_flag),
   .evt_amount  (evt_amount),
   .rd_valid    (rd_valid),
   .flag_vec    (flag_vec),
   .done_val    (done_val)
);

// File: tb/syncflag_unit_test.sv
module syncflag_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NF         = 16;
   localparam int DW         = 32;
   localparam int RAND_STEPS = 3000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic          ins_slot = 1'b0;
   logic [5:0]    ins_op = '0;
   logic [3:0]    ins_flag = '0;
   logic [DW-1:0] ins_operand = '0;
   logic          stall;
   logic          evt_valid = 1'b0;
   logic [3:0]    evt_flag = '0;
   logic [DW-1:0] evt_amount = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   syncflag_unit uut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_op(ins_op),
      .ins_flag(ins_flag), .ins_operand(ins_operand), .stall(stall),
      .evt_valid(evt_valid), .evt_flag(evt_flag), .evt_amount(evt_amount),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [DW-1:0] mf [NF];
   logic [DW-1:0] m_done;
   logic [DW-1:0] m_pub;

   function automatic bit exp_stall(bit v, logic [5:0] op, logic [DW-1:0] f, logic [DW-1:0] o);
      if (!v) return 1'b0;
      case (op)
         6'd4: return (f == '0);
         6'd5: return (f != o);
         6'd6: return (f == o);
         6'd7: return !($signed(f) >  $signed(o));
         6'd8: return !($signed(f) >= $signed(o));
         6'd9: return !($signed(f) <  $signed(o));
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic step(string tag, bit v, bit sl, logic [5:0] op, logic [3:0] idx,
                       logic [DW-1:0] opd, bit ev, logic [3:0] ei, logic [DW-1:0] ea);
      bit            rv;
      logic [DW-1:0] rd;
      ins_valid = v; ins_slot = sl; ins_op = op; ins_flag = idx; ins_operand = opd;
      evt_valid = ev; evt_flag = ei; evt_amount = ea;
      #1;
      chk(tag, "stall", {31'd0, stall}, {31'd0, exp_stall(v, op, mf[idx], opd)});
      @(posedge clk);
      rv = v && sl && (op == 6'd21 || op == 6'd23);
      rd = (op == 6'd21) ? m_done : m_pub;
      if (v && op == 6'd10) mf[idx] = mf[idx] + opd;
      if (ev) mf[ei] = mf[ei] + ea;
      if (v && sl && op == 6'd22) m_done = opd;
      if (v && sl && op == 6'd24) m_pub = opd;
      @(negedge clk);
      chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, rv});
      if (rv) chk(tag, "rd_data", rd_data, rd);
   endtask

   task automatic ins(string tag, bit sl, logic [5:0] op, logic [3:0] idx, logic [DW-1:0] opd);
      step(tag, 1'b1, sl, op, idx, opd, 1'b0, 4'd0, '0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NF; i++) mf[i] = '0;
      m_done = '0; m_pub = '0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1", "stall in reset", {31'd0, stall}, 32'd0);
      chk("R1", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: flags zero, so DONE waits stall; registers read zero
      for (int i = 0; i < NF; i += 5) ins("R1", 1'b0, 6'd4, 4'(i), '0);
      ins("R1", 1'b1, 6'd21, 4'd0, '0);
      ins("R1", 1'b1, 6'd23, 4'd0, '0);

      // R5 / R2: gather pattern, event then GE wait, clear by negative add
      step("R5", 1'b0, 1'b0, 6'd0, 4'd0, '0, 1'b1, 4'd3, 32'd64);
      ins("R2", 1'b0, 6'd8, 4'd3, 32'd65);
      ins("R2", 1'b0, 6'd8, 4'd3, 32'd64);
      ins("R2", 1'b0, 6'd7, 4'd3, 32'd64);
      ins("R2", 1'b0, 6'd4, 4'd3, '0);
      ins("R4", 1'b1, 6'd10, 4'd3, -32'sd64);
      ins("R4", 1'b0, 6'd5, 4'd3, '0);
      ins("R2", 1'b0, 6'd6, 4'd3, '0);
      ins("R7", 1'b1, 6'd22, 4'd0, 32'h0000_0077);
      ins("R7", 1'b1, 6'd21, 4'd0, '0);
      // R8: slot 0 accesses ignored
      ins("R8", 1'b0, 6'd22, 4'd0, 32'h0000_0055);
      ins("R8", 1'b0, 6'd21, 4'd0, '0);
      ins("R8", 1'b0, 6'd24, 4'd0, 32'hDEAD_BEEF);
      ins("R8", 1'b1, 6'd21, 4'd0, '0);
      ins("R7", 1'b1, 6'd24, 4'd0, 32'h1234_5678);
      ins("R7", 1'b1, 6'd23, 4'd0, '0);
      // R3: signed compare, flag 7 = -1
      ins("R3", 1'b1, 6'd10, 4'd7, 32'hFFFF_FFFF);
      ins("R3", 1'b0, 6'd7, 4'd7, 32'd1);
      ins("R3", 1'b0, 6'd9, 4'd7, 32'd1);
      ins("R3", 1'b0, 6'd8, 4'd7, 32'h8000_0000);
      // R4: wrap at the top of the signed range
      ins("R4", 1'b1, 6'd10, 4'd9, 32'h7FFF_FFFF);
      ins("R4", 1'b1, 6'd10, 4'd9, 32'd1);
      ins("R4", 1'b0, 6'd5, 4'd9, 32'h8000_0000);
      ins("R3", 1'b0, 6'd9, 4'd9, '0);
      // R6: instruction add and event add on the same flag
      step("R6", 1'b1, 1'b0, 6'd10, 4'd12, 32'd5, 1'b1, 4'd12, 32'd9);
      ins("R6", 1'b0, 6'd5, 4'd12, 32'd14);
      step("R6", 1'b1, 1'b1, 6'd10, 4'd12, -32'sd20, 1'b1, 4'd12, 32'd6);
      ins("R6", 1'b0, 6'd4, 4'd12, '0);
      // R9: unused opcodes and invalid cycles do nothing
      ins("R9", 1'b1, 6'd11, 4'd12, 32'd100);
      ins("R9", 1'b0, 6'd63, 4'd12, 32'd100);
      step("R9", 1'b0, 1'b1, 6'd10, 4'd12, 32'd100, 1'b0, 4'd0, '0);
      step("R9", 1'b0, 1'b1, 6'd4, 4'd0, '0, 1'b0, 4'd0, '0);
      ins("R9", 1'b0, 6'd5, 4'd12, '0);

      // constrained random mix
      for (int n = 0; n < RAND_STEPS; n++) begin
         logic [5:0]    op;
         logic [3:0]    idx;
         logic [DW-1:0] opd;
         bit            v;
         int            kind;
         kind = int'($urandom % 8);
         idx  = 4'($urandom);
         v    = 1'b1;
         opd  = DW'(int'($urandom % 9) - 4);
         case (kind)
            0, 1, 2, 3: begin
               op = 6'(4 + $urandom % 6);
               if ($urandom % 2 == 0) opd = mf[idx] + DW'(int'($urandom % 3) - 1);
            end
            4: op = 6'd10;
            5: begin op = 6'(21 + $urandom % 4); opd = $urandom; end
            6: op = 6'($urandom);
            default: begin op = 6'($urandom); v = 1'b0; end
         endcase
         step((kind < 4) ? "R2" : (kind == 4) ? "R4" : (kind == 5) ? "R7" : "R9",
              v, 1'($urandom), op, idx, opd,
              1'($urandom), 4'($urandom), DW'(int'($urandom % 7) - 3));
      end

      ins_valid = 1'b0; evt_valid = 1'b0;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule